// File: doc/BRIEF.md
# Configurable Lookup-Table Logic Cell

This block models one programmable logic cell. Its whole personality (two 16-entry truth tables, a mode choice, the data source of each flip-flop and whether each output is registered) sits in a single serial shift register. A loader fills that register after power-up by clocking bits in on a dedicated configuration clock while holding a load enable high. While loading, the user outputs are held low so that a half-written personality never reaches the outputs.

Once loaded, the cell works as one of two function generators. In wide mode the two tables together form one function of all five logic inputs, with the top input choosing the table. In split mode the two tables form two independent functions of the low four inputs. Each of the two flip-flops captures either its function output or a separate direct data input. The flip-flops share a user clock and a clock enable, and an asynchronous global reset clears both. Each output shows either its flip-flop or its function output directly.

Top module: `lut_cell`

## Requirements
- R1: On each rising `cfgClk` edge while `cfgLoad` is high, `cfgData` enters the chain. A full load is 37 bits, sent in this order: table A entries 15 down to 0, table B entries 15 down to 0, mode (1 = wide), source A, source B, registered A, registered B. A source bit of 1 selects `dataIn` and a registered bit of 1 selects the flip-flop.
- R2: Rising `cfgClk` edges while `cfgLoad` is low leave the configuration unchanged.
- R3: In wide mode, both function outputs equal table B at index `lutIn[3:0]` when `lutIn[4]` is 1, and table A at that index when `lutIn[4]` is 0.
- R4: In split mode, function A is table A at index `lutIn[3:0]` and function B is table B at index `lutIn[3:0]`. `lutIn[4]` has no effect in this mode.
- R5: An output whose registered bit is 0 follows its function output combinationally.
- R6: An output whose registered bit is 1 shows the value its flip-flop captured on the last rising `clk` edge at which `clkEn` was high.
- R7: A rising `clk` edge with `clkEn` low leaves both flip-flops unchanged.
- R8: A flip-flop whose source bit is 1 captures `dataIn` in place of its function output.
- R9: `rstGlobal` high clears both flip-flops at once, without waiting for a clock edge and regardless of `clkEn`.
- R10: Both outputs are 0 while `cfgLoad` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfgClk | input | 1 | Configuration shift clock |
| cfgData | input | 1 | Serial configuration bit |
| cfgLoad | input | 1 | Configuration load enable; also blanks the outputs |
| clk | input | 1 | User clock for both flip-flops |
| clkEn | input | 1 | Shared flip-flop clock enable |
| rstGlobal | input | 1 | Asynchronous active-high flip-flop clear |
| lutIn | input | 5 | Logic inputs to the function generator |
| dataIn | input | 1 | Direct flip-flop data input |
| outA | output | 1 | Cell output A |
| outB | output | 1 | Cell output B |

## Verification
Combinational outputs are due in the same cycle as their inputs. The bench applies each input pattern, waits one time unit and then compares against its own table model, with no clock edge involved. Registered outputs change one `clk` edge after capture. The bench drives inputs at the falling edge and compares at the next falling edge, so exactly one rising edge falls in between. A reset clear and output blanking take effect at once, and each is sampled a time unit after the control signal changes, between clock edges.

// File: rtl/lut_cell_pkg.sv
`timescale 1ns/1ps
package lut_cell_pkg;
  parameter int ADDR_W   = 4;
  parameter int NUM_SLICE = 2;
  localparam int TBL_DEPTH = 1 << ADDR_W;
  localparam int CFG_LEN   = NUM_SLICE * TBL_DEPTH + 1 + 2 * NUM_SLICE;

  typedef struct packed {
    logic [NUM_SLICE-1:0][TBL_DEPTH-1:0] lutBits;
    logic                                wideMode;
    logic [NUM_SLICE-1:0]                srcDirect;
    logic [NUM_SLICE-1:0]                outReg;
    logic                                blank;
  } cellStrobes_t;
endpackage

// File: rtl/lut_cell_ctrl.sv
`timescale 1ns/1ps
module lut_cell_ctrl
  import lut_cell_pkg::*;
(
  input  logic         cfgClk,
  input  logic         cfgData,
  input  logic         cfgLoad,
  input  logic         rstGlobal,
  output cellStrobes_t strobes
);
  logic [CFG_LEN-1:0] cfgReg;
  logic               pastValid;

  always_ff @(posedge cfgClk) begin
    if (cfgLoad) cfgReg <= {cfgReg[CFG_LEN-2:0], cfgData};
  end

  always_ff @(posedge cfgClk) pastValid <= 1'b1;

  localparam int MODE_POS = 2 * NUM_SLICE;

  always_comb begin
    strobes.blank    = cfgLoad;
    strobes.wideMode = cfgReg[MODE_POS];
  end

  // Slice 0 fields are shifted before slice 1 fields, so they sit higher.
  for (genvar s = 0; s < NUM_SLICE; s++) begin : g_decode
    always_comb begin
      strobes.lutBits[s]   = cfgReg[CFG_LEN-1-s*TBL_DEPTH -: TBL_DEPTH];
      strobes.srcDirect[s] = cfgReg[2*NUM_SLICE-1-s];
      strobes.outReg[s]    = cfgReg[NUM_SLICE-1-s];
    end
  end

  // R1
  shift_in_chk: assert property (@(posedge cfgClk) disable iff (rstGlobal)
    (pastValid && cfgLoad) |=> (cfgReg[0] == $past(cfgData)) &&
                               (cfgReg[CFG_LEN-1:1] == $past(cfgReg[CFG_LEN-2:0])));
  // R2
  cfg_hold_chk: assert property (@(posedge cfgClk) disable iff (rstGlobal)
    (pastValid && !cfgLoad) |=> $stable(cfgReg));
endmodule

// File: rtl/lut_cell_datapath.sv
`timescale 1ns/1ps
module lut_cell_datapath
  import lut_cell_pkg::*;
(
  input  logic                 clk,
  input  logic                 clkEn,
  input  logic                 rstGlobal,
  input  logic [ADDR_W:0]      lutIn,
  input  logic                 dataIn,
  input  cellStrobes_t         strobes,
  output logic [NUM_SLICE-1:0] cellOut
);
  logic [ADDR_W-1:0]    addr;
  logic                 wideVal;
  logic [NUM_SLICE-1:0] fnOut;
  logic [NUM_SLICE-1:0] ffD;
  logic [NUM_SLICE-1:0] ffQ;

  assign addr    = lutIn[ADDR_W-1:0];
  assign wideVal = strobes.lutBits[lutIn[ADDR_W] ? 1 : 0][addr];

  for (genvar s = 0; s < NUM_SLICE; s++) begin : g_slice
    always_comb begin
      fnOut[s] = strobes.wideMode ? wideVal : strobes.lutBits[s][addr];
      ffD[s]   = strobes.srcDirect[s] ? dataIn : fnOut[s];
      cellOut[s] = strobes.blank ? 1'b0 : (strobes.outReg[s] ? ffQ[s] : fnOut[s]);
    end

    always_ff @(posedge clk or posedge rstGlobal) begin
      if (rstGlobal)  ffQ[s] <= 1'b0;
      else if (clkEn) ffQ[s] <= ffD[s];
    end

    // R6
    capture_chk: assert property (@(posedge clk) disable iff (rstGlobal)
      clkEn |=> ffQ[s] == $past(ffD[s]));
    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rstGlobal)
      !clkEn |=> $stable(ffQ[s]));
    // R9
    reset_clear_chk: assert property (@(posedge clk) rstGlobal |-> ffQ[s] == 1'b0);
    // R10
    blank_out_chk: assert property (@(posedge clk) disable iff (rstGlobal)
      strobes.blank |-> cellOut[s] == 1'b0);
  end
endmodule

// File: rtl/lut_cell.sv
`timescale 1ns/1ps
module lut_cell
  import lut_cell_pkg::*;
(
  input  logic          cfgClk,
  input  logic          cfgData,
  input  logic          cfgLoad,
  input  logic          clk,
  input  logic          clkEn,
  input  logic          rstGlobal,
  input  logic [ADDR_W:0] lutIn,
  input  logic          dataIn,
  output logic          outA,
  output logic          outB
);
  cellStrobes_t         strobes;
  logic [NUM_SLICE-1:0] cellOut;

  lut_cell_ctrl u_ctrl (
    .cfgClk(cfgClk), .cfgData(cfgData), .cfgLoad(cfgLoad),
    .rstGlobal(rstGlobal), .strobes(strobes)
  );

  lut_cell_datapath u_dp (
    .clk(clk), .clkEn(clkEn), .rstGlobal(rstGlobal), .lutIn(lutIn),
    .dataIn(dataIn), .strobes(strobes), .cellOut(cellOut)
  );

  assign outA = cellOut[0];
  assign outB = cellOut[1];
endmodule

// File: tb/lut_cell_bench.sv
`timescale 1ns/1ps
module lut_cell_bench;
  logic cfgClk = 0, cfgData = 0, cfgLoad = 0;
  logic clk = 0, clkEn = 0, rstGlobal = 0, dataIn = 0;
  logic [4:0] lutIn = '0;
  logic outA, outB;
  int nChecks = 0, nFails = 0;

  lut_cell u_lut_cell (.*);

  always #5 clk = ~clk;

  function automatic logic [36:0] mkCfg(logic [15:0] ta, logic [15:0] tb, logic wide,
                                        logic sa, logic sb, logic ra, logic rb);
    return {ta, tb, wide, sa, sb, ra, rb};
  endfunction

  // Reference function value for slice s (0 = A, 1 = B).
  function automatic logic refFn(logic [36:0] c, logic [4:0] x, int s);
    logic [15:0] ta, tb;
    ta = c[36:21];
    tb = c[20:5];
    if (c[4]) return x[4] ? tb[x[3:0]] : ta[x[3:0]];
    return (s == 0) ? ta[x[3:0]] : tb[x[3:0]];
  endfunction

  task automatic check(string req, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // R1: shift 37 bits, first bit first; R10 checked midway through the load.
  task automatic loadCfg(logic [36:0] w);
    cfgLoad = 1;
    for (int i = 36; i >= 0; i--) begin
      cfgData = w[i];
      #3 cfgClk = 1;
      #3 cfgClk = 0;
      if (i == 20) begin
        #1;
        check("R10 outA blank", outA, 1'b0);
        check("R10 outB blank", outB, 1'b0);
      end
    end
    cfgLoad = 0;
    #1;
  endtask

  task automatic sweepComb(logic [36:0] c, string req);
    for (int x = 0; x < 32; x++) begin
      lutIn = x[4:0];
      #1;
      check(req, outA, refFn(c, x[4:0], 0));
      check(req, outB, refFn(c, x[4:0], 1));
    end
  endtask

  task automatic testCombRandom();
    for (int k = 0; k < 8; k++) begin
      logic [36:0] c;
      c = mkCfg($urandom, $urandom, k[0], 1'b0, 1'b0, 1'b0, 1'b0);
      loadCfg(c);
      sweepComb(c, k[0] ? "R1 R3 R5 wide" : "R1 R4 R5 split");
    end
  endtask

  task automatic testReset();
    logic [36:0] c;
    c = mkCfg(16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    loadCfg(c);
    @(negedge clk); clkEn = 1; lutIn = 5'd3;
    @(negedge clk);
    check("R6 captured ones A", outA, 1'b1);
    check("R6 captured ones B", outB, 1'b1);
    #2 rstGlobal = 1;
    #1;
    check("R9 async clear A", outA, 1'b0);
    check("R9 async clear B", outB, 1'b0);
    @(negedge clk);
    check("R9 reset beats clkEn A", outA, 1'b0);
    check("R9 reset beats clkEn B", outB, 1'b0);
    rstGlobal = 0; clkEn = 0;
  endtask

  task automatic testRegistered();
    logic [36:0] c;
    c = mkCfg($urandom, $urandom, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    loadCfg(c);
    clkEn = 1;
    for (int x = 0; x < 16; x++) begin
      @(negedge clk); lutIn = x[4:0];
      @(negedge clk);
      check("R6 reg A", outA, refFn(c, x[4:0], 0));
      check("R6 reg B", outB, refFn(c, x[4:0], 1));
    end
    // R7: clock enable low holds the last capture while inputs change.
    @(negedge clk); clkEn = 0;
    for (int x = 0; x < 16; x++) begin
      lutIn = x[4:0];
      @(negedge clk);
      check("R7 hold A", outA, refFn(c, 5'd15, 0));
      check("R7 hold B", outB, refFn(c, 5'd15, 1));
    end
  endtask

  task automatic testDirect();
    logic [36:0] c;
    c = mkCfg(16'h0000, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    loadCfg(c);
    @(negedge clk); clkEn = 1; dataIn = 1;
    @(negedge clk);
    check("R8 direct A high", outA, 1'b1);
    check("R8 direct B high", outB, 1'b1);
    dataIn = 0;
    @(negedge clk);
    check("R8 direct A low", outA, 1'b0);
    check("R8 direct B low", outB, 1'b0);
    clkEn = 0;
  endtask

  task automatic testHoldCfg();
    logic [36:0] c;
    c = mkCfg(16'hA5C3, 16'h3C69, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    loadCfg(c);
    // R2: shift edges with load low must not disturb the personality.
    for (int i = 0; i < 10; i++) begin
      cfgData = ~cfgData;
      #3 cfgClk = 1;
      #3 cfgClk = 0;
    end
    sweepComb(c, "R2 cfg held");
    // R10: raising load alone blanks both outputs.
    lutIn = 5'd0;
    cfgLoad = 1;
    #1;
    check("R10 blank A", outA, 1'b0);
    check("R10 blank B", outB, 1'b0);
    cfgLoad = 0;
    #1;
  endtask

  bit finished = 0;

  initial begin
    rstGlobal = 1;
    #12 rstGlobal = 0;
    testCombRandom();
    testReset();
    testRegistered();
    testDirect();
    testHoldCfg();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule